// File: doc/BRIEF.md
# Interrupt Line Routing Crossbar

This block steers seventeen device interrupt lines onto four output interrupt wires. Each line owns a two-bit route field that picks one output wire. The fields are spread across two 32-bit route registers. Each output wire is the OR of every active line whose field selects it. The outputs are plain levels with no latching. Software loads and reads back the two route registers through a simple write and read port.

A mode input picks routed operation or legacy operation. In routed mode the device lines go to the four wires and are taken out of the residual vector handed to the legacy summary path. Internal, non-device sources are never routed and always reach that path. In legacy mode the four wires stay low and the full vector goes to the legacy path. A write that tries to program route fields while in legacy mode is still stored, but it does not route anything and raises a one-cycle warning pulse.

Top module: `irq_route_xbar`

## Requirements
- R1: After reset both route registers read as zero, so every device line drives output wire 0, and `cfg_warn` is low.
- R2: Device line i, for i from 0 to 13, takes its route field from register B (`wr_sel`/`rd_sel` = 1) at bits [27-2i:26-2i]. A field value k selects output wire k.
- R3: Device line j, for j from 14 to 16, takes its route field from register A (`wr_sel`/`rd_sel` = 0) at bits [23-2(j-14):22-2(j-14)]. A field value k selects output wire k.
- R4: In routed mode (`routed_mode` = 1) `irq_out[k]` is the combinational OR of all active device lines whose field equals k. Register bits outside the route fields have no effect on routing.
- R5: In routed mode `residual[16:0]` (the device lines) is all zero and `residual[20:17]` equals `int_irq`.
- R6: In legacy mode (`routed_mode` = 0) `irq_out` is all zero and `residual` equals `{int_irq, dev_irq}`, whatever the route registers hold.
- R7: `legacy_irq` is high exactly when any bit of `residual` is high.
- R8: A write made in legacy mode whose data has any bit set in a route-field range pulses `cfg_warn` high for exactly the next cycle. The ranges are register A bits [23:18] and register B bits [27:0]. Writes in routed mode, and legacy writes that touch only other bits, give no pulse.
- R9: A write stores all 32 bits, and `rd_data` shows the register picked by `rd_sel` exactly as written. The new routing takes effect on the outputs from the clock edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| routed_mode | input | 1 | 1 = routed mode, 0 = legacy mode |
| dev_irq | input | 17 | Active-high device interrupt lines |
| int_irq | input | 4 | Internal non-device interrupt sources |
| wr_en | input | 1 | Route register write strobe |
| wr_sel | input | 1 | Write target: 0 = register A, 1 = register B |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 = register A, 1 = register B |
| rd_data | output | 32 | Selected route register contents |
| irq_out | output | 4 | Routed output interrupt wires |
| residual | output | 21 | Vector passed to the legacy path, {internal, device} |
| legacy_irq | output | 1 | OR of the residual vector |
| cfg_warn | output | 1 | One-cycle pulse after a route write in legacy mode |

## Verification
The properties assume that `routed_mode` and the interrupt inputs are steady, known levels when sampled at each clock edge, and that `wr_sel` and `rd_sel` are known whenever a write or read is checked. The bench changes every input only on the falling clock edge. It holds the mode fixed across each write, so that the warning pulse is always judged against the mode that was present at the write edge.

// File: rtl/irq_xbar_pkg.sv
package irq_xbar_pkg;

    localparam int LINES  = 17;
    localparam int OUTS   = 4;
    localparam int SEL_W  = $clog2(OUTS);
    localparam int REG_W  = 32;
    localparam int INT_W  = 4;
    localparam int SPLIT  = 14;
    localparam int B_TOP  = 27;
    localparam int A_TOP  = 23;
    localparam int RES_W  = LINES + INT_W;

    typedef logic [SEL_W-1:0] sel_t;

    typedef enum logic {
        ROUTE_A = 1'b0,
        ROUTE_B = 1'b1
    } route_id_e;

    typedef struct packed {
        logic [REG_W-1:0] rb;
        logic [REG_W-1:0] ra;
    } route_cfg_t;

    function automatic sel_t field_of(route_cfg_t c, int line);
        sel_t f;
        if (line < SPLIT)
            f = c.rb[B_TOP - SEL_W*line -: SEL_W];
        else
            f = c.ra[A_TOP - SEL_W*(line - SPLIT) -: SEL_W];
        return f;
    endfunction

    function automatic logic [REG_W-1:0] field_mask(route_id_e id);
        logic [REG_W-1:0] m;
        m = '0;
        for (int l = 0; l < LINES; l++) begin
            for (int b = 0; b < SEL_W; b++) begin
                if (id == ROUTE_B && l < SPLIT)
                    m[B_TOP - SEL_W*l - b] = 1'b1;
                if (id == ROUTE_A && l >= SPLIT)
                    m[A_TOP - SEL_W*(l - SPLIT) - b] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_xbar_cfg.sv
module irq_xbar_cfg
    import irq_xbar_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             routed_mode,
    input  logic             wr_en,
    input  route_id_e        wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  route_id_e        rd_sel,
    output logic [REG_W-1:0] rd_data,
    output route_cfg_t       cfg,
    output logic             warn
);

    localparam logic [REG_W-1:0] MASK_A = field_mask(ROUTE_A);
    localparam logic [REG_W-1:0] MASK_B = field_mask(ROUTE_B);

    route_cfg_t cfg_q;
    logic       warn_q;
    logic [REG_W-1:0] hit_mask;

    always_comb begin
        hit_mask = (wr_sel == ROUTE_B) ? MASK_B : MASK_A;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            warn_q <= 1'b0;
        end else begin
            if (wr_en) begin
                if (wr_sel == ROUTE_B)
                    cfg_q.rb <= wr_data;
                else
                    cfg_q.ra <= wr_data;
            end
            warn_q <= wr_en && !routed_mode && ((wr_data & hit_mask) != '0);
        end
    end

    always_comb begin
        rd_data = (rd_sel == ROUTE_B) ? cfg_q.rb : cfg_q.ra;
    end

    assign cfg  = cfg_q;
    assign warn = warn_q;

endmodule

// File: rtl/irq_xbar_decode.sv
module irq_xbar_decode
    import irq_xbar_pkg::*;
#(
    parameter int NUM_LINES = LINES
)(
    input  route_cfg_t                  cfg,
    output logic [NUM_LINES-1:0][SEL_W-1:0] sel
);

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        assign sel[l] = field_of(cfg, l);
    end

endmodule

// File: rtl/irq_xbar_merge.sv
module irq_xbar_merge
    import irq_xbar_pkg::*;
#(
    parameter int NUM_LINES = LINES,
    parameter int NUM_OUTS  = OUTS,
    parameter int NUM_INT   = INT_W
)(
    input  logic                            routed_mode,
    input  logic [NUM_LINES-1:0]            dev_irq,
    input  logic [NUM_INT-1:0]              int_irq,
    input  logic [NUM_LINES-1:0][SEL_W-1:0] sel,
    output logic [NUM_OUTS-1:0]             irq_out,
    output logic [NUM_INT+NUM_LINES-1:0]    residual,
    output logic                            legacy_irq
);

    logic [NUM_OUTS-1:0][NUM_LINES-1:0] hit;

    for (genvar o = 0; o < NUM_OUTS; o++) begin : g_out
        for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
            assign hit[o][l] = dev_irq[l] && (sel[l] == SEL_W'(o));
        end
        assign irq_out[o] = routed_mode && (|hit[o]);
    end

    always_comb begin
        residual = {int_irq, (routed_mode ? {NUM_LINES{1'b0}} : dev_irq)};
    end

    assign legacy_irq = |residual;

endmodule

// File: rtl/irq_route_xbar.sv
module irq_route_xbar
    import irq_xbar_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               routed_mode,
    input  logic [LINES-1:0]   dev_irq,
    input  logic [INT_W-1:0]   int_irq,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               rd_sel,
    output logic [REG_W-1:0]   rd_data,
    output logic [OUTS-1:0]    irq_out,
    output logic [RES_W-1:0]   residual,
    output logic               legacy_irq,
    output logic               cfg_warn
);

    route_cfg_t                  cfg;
    logic [LINES-1:0][SEL_W-1:0] sel;

    irq_xbar_cfg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .routed_mode (routed_mode),
        .wr_en       (wr_en),
        .wr_sel      (route_id_e'(wr_sel)),
        .wr_data     (wr_data),
        .rd_sel      (route_id_e'(rd_sel)),
        .rd_data     (rd_data),
        .cfg         (cfg),
        .warn        (cfg_warn)
    );

    irq_xbar_decode #(.NUM_LINES(LINES)) u_dec (
        .cfg (cfg),
        .sel (sel)
    );

    irq_xbar_merge #(
        .NUM_LINES (LINES),
        .NUM_OUTS  (OUTS),
        .NUM_INT   (INT_W)
    ) u_merge (
        .routed_mode (routed_mode),
        .dev_irq     (dev_irq),
        .int_irq     (int_irq),
        .sel         (sel),
        .irq_out     (irq_out),
        .residual    (residual),
        .legacy_irq  (legacy_irq)
    );

endmodule

// File: rtl/irq_route_xbar_chk.sv
module irq_route_xbar_chk
    import irq_xbar_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             routed_mode,
    input logic [LINES-1:0] dev_irq,
    input logic [INT_W-1:0] int_irq,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [REG_W-1:0] wr_data,
    input logic             rd_sel,
    input logic [REG_W-1:0] rd_data,
    input logic [OUTS-1:0]  irq_out,
    input logic [RES_W-1:0] residual,
    input logic             legacy_irq,
    input logic             cfg_warn
);

    localparam logic [REG_W-1:0] CHK_MASK_A = 32'h00FC_0000;
    localparam logic [REG_W-1:0] CHK_MASK_B = 32'h0FFF_FFFF;

    // R6
    legacy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !routed_mode |-> (irq_out == '0 && residual == {int_irq, dev_irq}));

    // R5
    routed_strip_chk: assert property (@(posedge clk) disable iff (rst)
        routed_mode |-> (residual[LINES-1:0] == '0 && residual[RES_W-1:LINES] == int_irq));

    // R4
    no_source_no_out_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_irq == '0) |-> (irq_out == '0));

    // R4
    active_line_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (routed_mode && dev_irq != '0) |-> (irq_out != '0));

    // R7
    summary_match_chk: assert property (@(posedge clk) disable iff (rst)
        legacy_irq == (residual != '0));

    // R8
    warn_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !routed_mode &&
         ((wr_data & (wr_sel ? CHK_MASK_B : CHK_MASK_A)) != '0)) |=> cfg_warn);

    // R8
    warn_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && !routed_mode &&
          ((wr_data & (wr_sel ? CHK_MASK_B : CHK_MASK_A)) != '0)) |=> !cfg_warn);

    // R9
    readback_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (rd_sel == wr_sel)) |=>
            (rd_sel != $past(rd_sel) || rd_data == $past(wr_data)));

endmodule

bind irq_route_xbar irq_route_xbar_chk u_chk (.*);

// File: tb/irq_route_xbar_tb.sv
module irq_route_xbar_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        routed_mode = 1'b0;
    logic [16:0] dev_irq = '0;
    logic [3:0]  int_irq = '0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic [3:0]  irq_out;
    logic [20:0] residual;
    logic        legacy_irq;
    logic        cfg_warn;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_route_xbar u_dut (.*);

    typedef struct packed {
        logic [31:0] ra;
        logic [31:0] rb;
        logic [16:0] dev;
        logic [3:0]  intr;
        logic        mode;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0000, 32'h0000_0000, 17'h1FFFF, 4'h0, 1'b1},
        '{32'h00FC_0000, 32'h0FFF_FFFF, 17'h00001, 4'h0, 1'b1},
        '{32'h0054_0000, 32'h0555_5555, 17'h10000, 4'hA, 1'b1},
        '{32'h00A8_0000, 32'h0AAA_AAAA, 17'h00000, 4'h5, 1'b1},
        '{32'h0064_0000, 32'h0E4E_4E4E, 17'h0A5A5, 4'h3, 1'b1},
        '{32'h00FC_0000, 32'h0E4E_4E4E, 17'h1C003, 4'h0, 1'b1},
        '{32'hFF03_FFFF, 32'hF000_0000, 17'h1FFFF, 4'h1, 1'b1},
        '{32'h00FC_0000, 32'h0FFF_FFFF, 17'h1FFFF, 4'h6, 1'b0},
        '{32'h0054_0000, 32'h0555_5555, 17'h00000, 4'h0, 1'b0}
    };

    function automatic logic [1:0] model_sel(logic [31:0] ra, logic [31:0] rb, int l);
        if (l < 14) return 2'((rb >> (26 - 2*l)) & 32'h3);
        return 2'((ra >> (22 - 2*(l - 14))) & 32'h3);
    endfunction

    function automatic logic [3:0] model_out(logic [31:0] ra, logic [31:0] rb,
                                             logic [16:0] dev, logic mode);
        logic [3:0] o = '0;
        if (mode)
            for (int l = 0; l < 17; l++)
                if (dev[l]) o[model_sel(ra, rb, l)] = 1'b1;
        return o;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic sel, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd_sel = 1'b0; #1; chk("R1 regA", rd_data, 32'h0);
        rd_sel = 1'b1; #1; chk("R1 regB", rd_data, 32'h0);
        chk("R1 warn", {31'b0, cfg_warn}, 32'h0);
        routed_mode = 1'b1; dev_irq = 17'h10001; #1;
        chk("R1 out0", {28'b0, irq_out}, 32'h1);

        // R4 R5 R6 R7: table walk
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            routed_mode = VECS[v].mode;
            wr(1'b0, VECS[v].ra);
            wr(1'b1, VECS[v].rb);
            dev_irq = VECS[v].dev; int_irq = VECS[v].intr;
            #1;
            chk(VECS[v].mode ? "R4 out" : "R6 out", {28'b0, irq_out},
                {28'b0, model_out(VECS[v].ra, VECS[v].rb, VECS[v].dev, VECS[v].mode)});
            chk(VECS[v].mode ? "R5 residual" : "R6 residual", {11'b0, residual},
                {11'b0, VECS[v].intr, (VECS[v].mode ? 17'h0 : VECS[v].dev)});
            chk("R7 summary", {31'b0, legacy_irq},
                {31'b0, (VECS[v].intr != 0) || (!VECS[v].mode && VECS[v].dev != 0)});
        end

        // R2 R3: each line, each field value, one line active
        routed_mode = 1'b1; int_irq = '0;
        for (int l = 0; l < 17; l++) begin
            for (int k = 0; k < 4; k++) begin
                logic [31:0] d;
                d = (l < 14) ? (32'(k) << (26 - 2*l)) : (32'(k) << (22 - 2*(l - 14)));
                wr((l < 14) ? 1'b1 : 1'b0, d);
                dev_irq = 17'(1) << l; #1;
                chk((l < 14) ? "R2 field" : "R3 field", {28'b0, irq_out}, 32'(1) << k);
                dev_irq = '0;
                wr((l < 14) ? 1'b1 : 1'b0, 32'h0);
            end
        end

        // R9: readback of all bits and same-edge effect
        wr(1'b0, 32'hDEAD_BEEF);
        rd_sel = 1'b0; #1; chk("R9 readback A", rd_data, 32'hDEAD_BEEF);
        @(negedge clk); dev_irq = 17'h00001;
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'h0C00_0000;
        @(negedge clk); wr_en = 1'b0; #1;
        chk("R9 effect", {28'b0, irq_out}, 32'h8);
        rd_sel = 1'b1; #1; chk("R9 readback B", rd_data, 32'h0C00_0000);
        dev_irq = '0;

        // R8: warning pulse
        routed_mode = 1'b0;
        @(negedge clk); wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0004_0000;
        @(negedge clk); wr_en = 1'b0; #1;
        chk("R8 pulse A", {31'b0, cfg_warn}, 32'h1);
        @(negedge clk); #1;
        chk("R8 one cycle", {31'b0, cfg_warn}, 32'h0);
        @(negedge clk); wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'hFF03_FFFF;
        @(negedge clk); wr_en = 1'b0; #1;
        chk("R8 outside bits", {31'b0, cfg_warn}, 32'h0);
        @(negedge clk); wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'h0000_0001;
        @(negedge clk); wr_en = 1'b0; #1;
        chk("R8 pulse B", {31'b0, cfg_warn}, 32'h1);
        @(negedge clk); wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'hF000_0000;
        @(negedge clk); wr_en = 1'b0; #1;
        chk("R8 B outside", {31'b0, cfg_warn}, 32'h0);
        routed_mode = 1'b1;
        @(negedge clk); wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'h0FFF_FFFF;
        @(negedge clk); wr_en = 1'b0; #1;
        chk("R8 routed none", {31'b0, cfg_warn}, 32'h0);

        // R6: legacy write stored but routing inert until routed mode
        routed_mode = 1'b0; dev_irq = 17'h00001; #1;
        chk("R6 legacy low", {28'b0, irq_out}, 32'h0);
        routed_mode = 1'b1; #1;
        chk("R6 back routed", {28'b0, irq_out}, 32'h8);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule